// File: doc/BRIEF.md
# Access-Frozen Time-of-Day Counter

This block keeps a seconds, minutes and hours count in BCD and freezes the visible value while a bus access is open. The bus interface reports the opening and closing of each access with single-cycle strobes. While an access is open, a one-second increment that falls due is stored rather than applied. It is then applied on the first fast reference tick after the access closes. A multi-byte read inside one access therefore always sees one coherent time value.

Reads split over two accesses get no such protection. If a rollover lands between the two accesses, the bytes can disagree. For example, hours may be read after a rollover while seconds were read before it.

A watchdog counts a slow (2 Hz) tick from the first opening strobe of an access. An extra opening strobe inside the same access does not restart the watchdog. When the configured count is reached, the block closes the hold by itself and pulses a forced-release output back to the bus interface. A forced release is treated exactly like a normal close.

Top module: `hold_time_counter`

## Requirements
- R1: After reset, seconds, minutes and hours read 8'h00, and `hold_o` and `force_release_o` are low.
- R2: With no access open, each cycle with `sec_tick_i` high advances the seconds field by one. The new value is visible after that clock edge.
- R3: Fields count in packed BCD (upper nibble tens, lower nibble units). Seconds run 00..59 and minutes 00..59, each carrying into the next field on wrap. Hours run 00..23 and wrap to 00.
- R4: A `start_i` strobe with no access open raises `hold_o` from the next cycle. While `hold_o` is high, the time outputs do not change.
- R5: A seconds tick that arrives while `hold_o` is high is kept pending. It is applied on the first `ref_tick_i` seen after `hold_o` falls, and reference ticks during the hold do not apply it.
- R6: A `stop_i` strobe while `hold_o` is high clears `hold_o` from the next cycle.
- R7: When `TIMEOUT_TICKS` pulses of `half_tick_i` have arrived during one access, `hold_o` falls and `force_release_o` is high for exactly one cycle.
- R8: A `start_i` strobe while `hold_o` is already high does not restart the watchdog count.
- R9: A forced release leaves a pending seconds tick to be applied on the next `ref_tick_i`, as a stop would.
- R10: If a new seconds tick and the reference tick that applies a pending tick arrive in the same cycle with no hold, both are counted: seconds advance by one at once and by one more on a later reference tick.
- R11: `half_tick_i` pulses outside an access do not count toward the watchdog; each new access starts its count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access-open strobe from bus interface |
| stop_i | input | 1 | Access-close strobe from bus interface |
| sec_tick_i | input | 1 | One-second tick, one cycle wide |
| ref_tick_i | input | 1 | Fast reference tick (about 16 kHz), one cycle wide |
| half_tick_i | input | 1 | 2 Hz watchdog tick, one cycle wide |
| hold_o | output | 1 | Access hold active |
| force_release_o | output | 1 | One-cycle pulse when the watchdog ends an access |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |

## Verification
The bench builds the block with `TIMEOUT_TICKS` set to 3 rather than the default 2. The extra tick leaves room to place a repeated start between watchdog ticks and show that the count survives it. The field limits stay at their defaults. Holding the seconds tick high for long bursts walks the counter through the minute, hour and midnight wraps within the cycle budget.

// File: rtl/hold_time_pkg.sv
package hold_time_pkg;
  localparam int unsigned BCD_W = 8;
  typedef logic [BCD_W-1:0] bcd_t;

  function automatic bcd_t bcd_next(input bcd_t v, input bcd_t top);
    bcd_t r;
    if (v == top)            r = '0;
    else if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                     r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/bcd_field.sv
module bcd_field
  import hold_time_pkg::*;
#(
  parameter bcd_t TOP = 8'h59
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output bcd_t val_o,
  output logic carry_o
);
  bcd_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (inc_i) val_q <= bcd_next(val_q, TOP);
  end

  assign val_o   = val_q;
  assign carry_o = inc_i && (val_q == TOP);

  // R3
  bcd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_q <= TOP) && (val_q[3:0] <= 4'd9));
  // R3
  bcd_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && val_q == TOP) |=> (val_q == '0));
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl #(
  parameter int unsigned TIMEOUT_TICKS = 2,
  localparam int unsigned WD_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic sec_tick_i,
  input  logic ref_tick_i,
  input  logic half_tick_i,
  output logic hold_o,
  output logic force_o,
  output logic advance_o
);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_TICKS - 1);

  logic            hold_q, force_q, pend_q;
  logic [WD_W-1:0] wd_q;
  logic            open_w, fire_w, close_w, apply_w;

  assign open_w  = !hold_q && start_i;
  // stop wins over a simultaneous timeout
  assign fire_w  = hold_q && half_tick_i && (wd_q == WD_LAST) && !stop_i;
  assign close_w = hold_q && (stop_i || fire_w);
  assign apply_w = !hold_q && pend_q && ref_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      force_q <= 1'b0;
      wd_q    <= '0;
    end else begin
      force_q <= fire_w;
      if (open_w) begin
        hold_q <= 1'b1;
        wd_q   <= '0;
      end else if (close_w) begin
        hold_q <= 1'b0;
      end else if (hold_q && half_tick_i) begin
        wd_q <= wd_q + 1'b1;
      end
    end
  end

  // at most one stored increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (hold_q && sec_tick_i)    pend_q <= 1'b1;
    else if (apply_w && !sec_tick_i)  pend_q <= 1'b0;
  end

  // a fresh tick goes now; a pending one waits for the next reference tick
  assign advance_o = !hold_q && (sec_tick_i || (pend_q && ref_tick_i));
  assign hold_o    = hold_q;
  assign force_o   = force_q;

  // R7
  force_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |=> !force_q);
  // R7
  force_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |-> !hold_q);
  // R5
  pend_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(hold_q));
  // R8
  wd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q < WD_W'(TIMEOUT_TICKS));
  // R6
  stop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && stop_i) |=> (!hold_q && !force_q));
endmodule

// File: rtl/hold_time_counter.sv
module hold_time_counter
  import hold_time_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 2,
  parameter bcd_t        SEC_TOP       = 8'h59,
  parameter bcd_t        MIN_TOP       = 8'h59,
  parameter bcd_t        HOUR_TOP      = 8'h23
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sec_tick_i,
  input  logic       ref_tick_i,
  input  logic       half_tick_i,
  output logic       hold_o,
  output logic       force_release_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o
);
  localparam int unsigned N_FIELDS = 3;
  localparam bcd_t FIELD_TOP [N_FIELDS] = '{SEC_TOP, MIN_TOP, HOUR_TOP};

  logic advance_w;
  logic [N_FIELDS:0] inc_w;
  bcd_t val_w [N_FIELDS];

  hold_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_hold_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .sec_tick_i  (sec_tick_i),
    .ref_tick_i  (ref_tick_i),
    .half_tick_i (half_tick_i),
    .hold_o      (hold_o),
    .force_o     (force_release_o),
    .advance_o   (advance_w)
  );

  assign inc_w[0] = advance_w;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    bcd_field #(.TOP(FIELD_TOP[g])) i_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc_w[g]),
      .val_o   (val_w[g]),
      .carry_o (inc_w[g+1])
    );
  end

  assign sec_o  = val_w[0];
  assign min_o  = val_w[1];
  assign hour_o = val_w[2];

  // R4
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable({hour_o, min_o, sec_o}));
  // R2
  idle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && sec_tick_i) |=> !$stable(sec_o));
endmodule

// File: tb/test_hold_time_counter.sv
module test_hold_time_counter;
  localparam int CLK_PERIOD = 10;
  localparam int TO_TICKS   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, sec_t = 0, ref_t = 0, half_t = 0;
  logic hold, force_rel;
  logic [7:0] sec, min, hour;
  int errors = 0, checks = 0;
  int total = 0;  // expected seconds since midnight

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_time_counter #(.TIMEOUT_TICKS(TO_TICKS)) i_hold_time_counter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .sec_tick_i(sec_t), .ref_tick_i(ref_t), .half_tick_i(half_t),
    .hold_o(hold), .force_release_o(force_rel),
    .sec_o(sec), .min_o(min), .hour_o(hour)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req);
    int t = total % 86400;
    chk(req, {8'h0, hour, min, sec},
        {8'h0, to_bcd(t / 3600), to_bcd((t / 60) % 60), to_bcd(t % 60)});
  endtask

  // one-cycle strobe; outputs settled at return
  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sec", sec, 8'h00); chk("R1 min", min, 8'h00);
    chk("R1 hour", hour, 8'h00);
    chk("R1 hold", hold, 0); chk("R1 force", force_rel, 0);
  endtask

  task automatic t_plain();
    for (int i = 0; i < 3; i++) begin strobe(sec_t); total++; end
    chk_time("R2 plain ticks");
  endtask

  task automatic t_hold();
    strobe(start);
    chk("R4 hold up", hold, 1);
    strobe(sec_t);
    chk_time("R4 frozen");
    strobe(ref_t);
    chk_time("R5 ref during hold ignored");
    strobe(stop);
    chk("R6 hold down", hold, 0);
    chk_time("R5 not applied before ref");
    strobe(ref_t); total++;
    chk_time("R5 applied on ref");
  endtask

  task automatic t_timeout();
    strobe(start);
    strobe(sec_t);
    strobe(half_t); strobe(half_t);
    chk("R7 still held", hold, 1);
    strobe(start);  // repeated start
    strobe(half_t);
    chk("R8 timeout from first start", hold, 0);
    chk("R7 force pulse", force_rel, 1);
    @(negedge clk);
    chk("R7 force one cycle", force_rel, 0);
    chk_time("R9 pending kept");
    strobe(ref_t); total++;
    chk_time("R9 applied after forced release");
  endtask

  task automatic t_idle_half();
    for (int i = 0; i < 5; i++) strobe(half_t);
    strobe(start);
    strobe(half_t); strobe(half_t);
    chk("R11 idle half ticks ignored", hold, 1);
    chk("R11 no force", force_rel, 0);
    strobe(stop);
  endtask

  task automatic t_same();
    strobe(start); strobe(sec_t); strobe(stop);
    @(negedge clk); sec_t = 1; ref_t = 1;
    @(negedge clk); sec_t = 0; ref_t = 0; total++;
    chk_time("R10 one applied now");
    strobe(ref_t); total++;
    chk_time("R10 second applied on ref");
  endtask

  task automatic burst_to(input int target);
    int n = target - total;
    if (n <= 0) return;
    @(negedge clk); sec_t = 1;
    repeat (n) @(negedge clk);
    sec_t = 0; total = target;
  endtask

  task automatic t_roll();
    burst_to(59);    chk_time("R3 00:00:59");
    burst_to(60);    chk_time("R3 minute carry");
    burst_to(3599);  chk_time("R3 00:59:59");
    burst_to(3600);  chk_time("R3 hour carry");
    burst_to(86399); chk_time("R3 23:59:59");
    burst_to(86400); chk_time("R3 midnight wrap");
  endtask

  initial begin
    #(CLK_PERIOD * 200_000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_plain();
    t_hold();
    t_timeout();
    t_idle_half();
    t_same();
    t_roll();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule